// File: doc/BRIEF.md
# Three-Phase Bridge Gate Control Logic

This block turns six commutation requests, a brake request and a thermal flag pair into registered gate enables for three half bridges. Each bridge has an upper (source) and a lower (sink) switch. The upper requests are active low and the lower requests active high. A phase whose two requests are both asserted has both of its switches turned off, so no request pattern can short the supply.

Braking runs in two steps. When the active-low brake input goes low, every switch turns off at once. After a programmable number of clock ticks, all three lower switches close, which shorts the motor windings. This lasts until the brake input returns high. The off interval lets the spinning motor feed other loads before it is braked. A thermal trip flag forces every switch off. The switches stay off until a separate recover flag is seen, even after the trip flag drops. Thermal shutdown outranks braking, and braking outranks commutation.

All raw inputs pass through two-flop synchronizers, and the gate enables are taken from flops. Each phase also reports a two-bit state code that is registered in step with the gates.

Top module: `bridge_gate_ctrl`

## Requirements
- R1: An upper request bit at 0 asks for that phase's upper switch; with no conflict and no override, the phase's `gate_hi` bit becomes 1.
- R2: A lower request bit at 1 asks for that phase's lower switch; with no conflict and no override, the phase's `gate_lo` bit becomes 1.
- R3: A phase whose upper request is 0 and lower request is 1 at the same time drives both gate bits 0; `gate_hi` and `gate_lo` of one phase are never both 1.
- R4: `phase_state[2i+1:2i]` reports phase i as 2'b10 when only its upper switch is on, 2'b01 when only its lower switch is on, and 2'b00 when both are off.
- R5: While `brk_n` is 0, all upper gates are 0. For the first `brk_delay` clock ticks of a brake, all lower gates are also 0, whatever the requests.
- R6: Once `brk_delay` ticks of the brake have passed, all three lower gates are 1 and all upper gates are 0 until `brk_n` returns to 1. With `brk_delay` = 0, the lower gates close at once.
- R7: The delay is loaded from `brk_delay` at the start of a brake. Changes to `brk_delay` while the brake is held have no effect on that brake.
- R8: A 1 on `ot_trip` turns all six gates off. They stay off after `ot_trip` falls, until `ot_clear` is 1 while `ot_trip` is 0. A trip and a clear seen together count as a trip.
- R9: Priority is thermal shutdown first, then braking, then the commutation decode.
- R10: A change on any input reaches the outputs on the third rising clock edge after it is set up: two synchronizer stages, then the output register.
- R11: While `rst` is 1, and on the first edge after reset, all gates are 0 and every phase state is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req_n | input | 3 | Upper switch requests, active low, bit i = phase i |
| lo_req | input | 3 | Lower switch requests, active high, bit i = phase i |
| brk_n | input | 1 | Brake request, active low |
| ot_trip | input | 1 | Over-temperature trip flag |
| ot_clear | input | 1 | Over-temperature recover flag |
| brk_delay | input | DLY_W | Brake off interval in clock ticks, loaded at brake start |
| gate_hi | output | 3 | Upper gate enables |
| gate_lo | output | 3 | Lower gate enables |
| phase_state | output | 6 | Two bits per phase: 10 high, 01 low, 00 tristate |

## Verification
All 64 request combinations are stepped through. This separates the active-low upper decode from the active-high lower decode, and shows that a conflicting pair turns off only its own phase. Brake runs with a delay of five ticks, with a delay of zero, and with the delay input changed while the brake is held. These runs separate the off interval from the low-side clamp and show that the delay is latched. Thermal pulses are applied during commutation, during a brake, and at the same time as a clear. They show the hysteresis hold, that a trip wins over a simultaneous clear, and the priority over braking. A behavioural model compares the outputs on every cycle, so any error in the three-edge latency also shows.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    localparam int PHASES = 3;

    typedef enum logic [1:0] {
        PH_FLOAT  = 2'b00,
        PH_SINK   = 2'b01,
        PH_SOURCE = 2'b10
    } phase_e;

    typedef enum logic [1:0] {
        MODE_RUN,
        MODE_COAST,
        MODE_CLAMP,
        MODE_TRIP
    } mode_e;

    typedef struct packed {
        logic [PHASES-1:0] hi;
        logic [PHASES-1:0] lo;
    } gate_t;

    // Decode requests; a phase asking for both switches gets neither.
    function automatic gate_t commutate(input logic [PHASES-1:0] up_n,
                                        input logic [PHASES-1:0] lo);
        gate_t g;
        for (int i = 0; i < PHASES; i++) begin
            g.hi[i] = ~up_n[i] & ~lo[i];
            g.lo[i] =  lo[i] &  up_n[i];
        end
        return g;
    endfunction

    function automatic phase_e encode(input logic hi, input logic lo);
        phase_e p;
        if (hi && !lo)      p = PH_SOURCE;
        else if (lo && !hi) p = PH_SINK;
        else                p = PH_FLOAT;
        return p;
    endfunction

endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
    parameter int          W    = 1,
    parameter logic [W-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= IDLE;
            q    <= IDLE;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard (
    input  logic clk,
    input  logic rst,
    input  logic trip,
    input  logic clear,
    output logic hot
);
    logic hot_q;

    // Trip wins over clear; the latch holds until a clear is seen.
    assign hot = trip | (hot_q & ~clear);

    always_ff @(posedge clk) begin
        if (rst) hot_q <= 1'b0;
        else     hot_q <= hot;
    end
endmodule

// File: rtl/brake_sequencer.sv
module brake_sequencer #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             brk_n,
    input  logic [DLY_W-1:0] delay,
    output logic             active,
    output logic             clamp
);
    logic [DLY_W-1:0] remain;

    assign active = ~brk_n;
    assign clamp  = active && (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (!active) begin
            remain <= delay;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/bridge_gate_ctrl.sv
module bridge_gate_ctrl
    import bridge_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PHASES-1:0]     up_req_n,
    input  logic [PHASES-1:0]     lo_req,
    input  logic                  brk_n,
    input  logic                  ot_trip,
    input  logic                  ot_clear,
    input  logic [DLY_W-1:0]      brk_delay,
    output logic [PHASES-1:0]     gate_hi,
    output logic [PHASES-1:0]     gate_lo,
    output logic [2*PHASES-1:0]   phase_state
);
    localparam int RAW_W = 2*PHASES + 3;
    localparam logic [RAW_W-1:0] RAW_IDLE = {{PHASES{1'b1}}, {PHASES{1'b0}}, 3'b100};

    logic [RAW_W-1:0]  raw, syn;
    logic [PHASES-1:0] s_up_n, s_lo;
    logic              s_brk_n, s_trip, s_clr;
    logic              hot, brk_act, brk_clamp;
    mode_e             mode;
    gate_t             run_g, nxt_g, gate_q;

    assign raw = {up_req_n, lo_req, brk_n, ot_trip, ot_clear};

    bridge_sync #(.W(RAW_W), .IDLE(RAW_IDLE)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(syn)
    );

    assign {s_up_n, s_lo, s_brk_n, s_trip, s_clr} = syn;

    thermal_guard u_therm (
        .clk(clk), .rst(rst), .trip(s_trip), .clear(s_clr), .hot(hot)
    );

    brake_sequencer #(.DLY_W(DLY_W)) u_brake (
        .clk(clk), .rst(rst), .brk_n(s_brk_n), .delay(brk_delay),
        .active(brk_act), .clamp(brk_clamp)
    );

    always_comb begin
        if (hot)            mode = MODE_TRIP;
        else if (brk_clamp) mode = MODE_CLAMP;
        else if (brk_act)   mode = MODE_COAST;
        else                mode = MODE_RUN;
    end

    assign run_g = commutate(s_up_n, s_lo);

    always_comb begin
        nxt_g = '0;
        unique case (mode)
            MODE_RUN:   nxt_g = run_g;
            MODE_CLAMP: nxt_g.lo = '1;
            default:    nxt_g = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) gate_q <= '0;
        else     gate_q <= nxt_g;
    end

    assign gate_hi = gate_q.hi;
    assign gate_lo = gate_q.lo;

    generate
        for (genvar p = 0; p < PHASES; p++) begin : g_phase
            phase_e st_q;
            always_ff @(posedge clk) begin
                if (rst) st_q <= PH_FLOAT;
                else     st_q <= encode(nxt_g.hi[p], nxt_g.lo[p]);
            end
            assign phase_state[2*p +: 2] = st_q;
        end
    endgenerate

endmodule

// File: rtl/bridge_gate_chk.sv
module bridge_gate_chk
    import bridge_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                brk_n,
    input logic                ot_trip,
    input logic [PHASES-1:0]   gate_hi,
    input logic [PHASES-1:0]   gate_lo,
    input logic [2*PHASES-1:0] phase_state
);
    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (rst)
        (gate_hi & gate_lo) == '0); // R3

    generate
        for (genvar p = 0; p < PHASES; p++) begin : g_code
            AST_CODE_HI: assert property (@(posedge clk) disable iff (rst)
                gate_hi[p] |-> phase_state[2*p +: 2] == 2'b10); // R4
            AST_CODE_OFF: assert property (@(posedge clk) disable iff (rst)
                (!gate_hi[p] && !gate_lo[p]) |-> phase_state[2*p +: 2] == 2'b00); // R4
        end
    endgenerate

    AST_TRIP_OFF: assert property (@(posedge clk) disable iff (rst)
        $past(ot_trip, 3) |-> (gate_hi == '0 && gate_lo == '0)); // R8

    AST_BRAKE_NO_UPPER: assert property (@(posedge clk) disable iff (rst)
        !$past(brk_n, 3) |-> gate_hi == '0); // R5

    AST_RESET_OFF: assert property (@(posedge clk)
        rst |=> (gate_hi == '0 && gate_lo == '0 && phase_state == '0)); // R11
endmodule

bind bridge_gate_ctrl bridge_gate_chk u_chk (
    .clk(clk), .rst(rst), .brk_n(brk_n), .ot_trip(ot_trip),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .phase_state(phase_state)
);

// File: tb/sim_bridge_gate_ctrl.sv
`timescale 1ns/1ps
module sim_bridge_gate_ctrl;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    up_req_n = 3'b111;
    logic [2:0]    lo_req = 3'b000;
    logic          brk_n = 1'b1;
    logic          ot_trip = 1'b0;
    logic          ot_clear = 1'b0;
    logic [DW-1:0] brk_delay = 16'd5;
    logic [2:0]    gate_hi, gate_lo;
    logic [5:0]    phase_state;

    int checks = 0;
    int errors = 0;
    string tag = "R11";

    always #2.5 clk = ~clk;

    bridge_gate_ctrl #(.DLY_W(DW)) u0 (
        .clk(clk), .rst(rst), .up_req_n(up_req_n), .lo_req(lo_req),
        .brk_n(brk_n), .ot_trip(ot_trip), .ot_clear(ot_clear),
        .brk_delay(brk_delay), .gate_hi(gate_hi), .gate_lo(gate_lo),
        .phase_state(phase_state)
    );

    // Reference model: input history queue, latency of two sync edges.
    typedef struct {
        bit [2:0] up_n;
        bit [2:0] lo;
        bit       brk_n;
        bit       trip;
        bit       clr;
    } smp_t;

    smp_t       hist[$];
    bit   [2:0] exp_hi, exp_lo;
    bit   [5:0] exp_st;
    bit         m_hot;
    int         m_elapsed;
    int         m_latch;

    function automatic smp_t idle_smp();
        smp_t s;
        s.up_n = 3'b111; s.lo = 3'b000; s.brk_n = 1'b1; s.trip = 1'b0; s.clr = 1'b0;
        return s;
    endfunction

    always @(posedge clk) begin
        smp_t v, cur;
        bit [2:0] h, l;
        bit       clamp;
        cur.up_n = up_req_n; cur.lo = lo_req; cur.brk_n = brk_n;
        cur.trip = ot_trip;  cur.clr = ot_clear;
        if (rst) begin
            hist.delete();
            hist.push_back(idle_smp());
            hist.push_back(idle_smp());
            m_hot = 0; m_elapsed = 0; m_latch = 0;
            exp_hi <= 0; exp_lo <= 0; exp_st <= 0;
        end else begin
            v = hist[0];
            if (v.trip)      m_hot = 1;
            else if (v.clr)  m_hot = 0;
            clamp = 0;
            if (v.brk_n) begin
                m_latch = int'(brk_delay);
                m_elapsed = 0;
            end else begin
                clamp = (m_elapsed >= m_latch);
                m_elapsed++;
            end
            h = 0; l = 0;
            if (m_hot) begin
                h = 0; l = 0;
            end else if (!v.brk_n) begin
                l = clamp ? 3'b111 : 3'b000;
            end else begin
                for (int i = 0; i < 3; i++) begin
                    bit wh, wl;
                    wh = !v.up_n[i];
                    wl = v.lo[i];
                    h[i] = wh && !wl;
                    l[i] = wl && !wh;
                end
            end
            exp_hi <= h;
            exp_lo <= l;
            for (int i = 0; i < 3; i++)
                exp_st[2*i +: 2] <= h[i] ? 2'b10 : (l[i] ? 2'b01 : 2'b00);
            void'(hist.pop_front());
            hist.push_back(cur);
        end
    end

    // Compare away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (gate_hi !== exp_hi || gate_lo !== exp_lo || phase_state !== exp_st) begin
                errors++;
                $display("FAIL %s t=%0t: hi=%b lo=%b st=%b expected hi=%b lo=%b st=%b",
                         tag, $time, gate_hi, gate_lo, phase_state, exp_hi, exp_lo, exp_st);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired: actual hung, expected completion");
        finish_run();
    end

    initial begin
        // R11: reset state
        step(3);
        checks++;
        if (gate_hi !== 3'b000 || gate_lo !== 3'b000 || phase_state !== 6'b0) begin
            errors++;
            $display("FAIL R11 reset: hi=%b lo=%b st=%b expected all zero",
                     gate_hi, gate_lo, phase_state);
        end
        rst = 1'b0;
        step(4);

        // R1 R2 R3 R4 R10: every request pattern, held for a few cycles
        tag = "R1 R2 R3 R4 R10";
        for (int k = 0; k < 64; k++) begin
            up_req_n = k[5:3];
            lo_req   = k[2:0];
            step(4);
        end
        // single-cycle changes stress the latency alignment
        for (int k = 0; k < 20; k++) begin
            up_req_n = 3'(k * 5);
            lo_req   = 3'(k * 3);
            step(1);
        end
        up_req_n = 3'b110; lo_req = 3'b010;   // phase0 high, phase1 low
        step(4);

        // R5 R6: brake with a delay of five ticks
        tag = "R5 R6 R9";
        brk_delay = 16'd5;
        brk_n = 1'b0;
        step(14);
        brk_n = 1'b1;
        step(5);

        // R7: delay changed while the brake is held
        tag = "R7";
        brk_delay = 16'd8;
        brk_n = 1'b0;
        step(4);
        brk_delay = 16'd1;
        step(12);
        brk_n = 1'b1;
        step(5);

        // R6: zero delay clamps at once
        tag = "R6";
        brk_delay = 16'd0;
        brk_n = 1'b0;
        step(6);
        brk_n = 1'b1;
        step(5);

        // R8: trip pulse, hold after it falls, then recover
        tag = "R8";
        up_req_n = 3'b011; lo_req = 3'b001;
        step(4);
        ot_trip = 1'b1;
        step(2);
        ot_trip = 1'b0;
        step(8);
        ot_clear = 1'b1;
        step(1);
        ot_clear = 1'b0;
        step(5);

        // R8: trip and clear together count as trip
        ot_trip = 1'b1; ot_clear = 1'b1;
        step(1);
        ot_trip = 1'b0;
        step(1);
        ot_clear = 1'b0;
        step(6);
        ot_clear = 1'b1;
        step(1);
        ot_clear = 1'b0;
        step(5);

        // R9: thermal outranks a clamped brake
        tag = "R9";
        brk_delay = 16'd2;
        brk_n = 1'b0;
        step(8);
        ot_trip = 1'b1;
        step(1);
        ot_trip = 1'b0;
        step(6);
        ot_clear = 1'b1;
        step(1);
        ot_clear = 1'b0;
        step(6);
        brk_n = 1'b1;
        step(6);

        finish_run();
    end
endmodule